// File: doc/BRIEF.md
# Subtract/Compare Status Flag Unit

This block is a datapath slice that subtracts a second operand from a first operand and records the outcome in a set of six arithmetic status flags. The second operand comes either from a full-width register input or from a narrower immediate input. The immediate is sign-extended to the full operand width before the subtraction. One select input chooses between two operations. A subtract stores the difference in an accumulator and updates the flags. A compare updates the same flags in the same way, but it throws the difference away and leaves the accumulator as it was.

The six flags are:
- an unsigned borrow (carry);
- a zero indication;
- the sign of the difference;
- a signed overflow;
- a borrow out of the low nibble (auxiliary carry);
- an even-parity indication over the low byte of the difference.

The accumulator and the flags are registered. They change on a rising clock edge only while the operation strobe is high.

The block accepts one operation on every clock cycle. It applies no back-pressure, so there is no ready signal. Each cycle in which the strobe is high consumes one operation. The result appears at the outputs after that clock edge.

Top module: `subcmp_flag_unit`

## Requirements
- R1: On an edge with `op_valid`=1, `op_is_cmp`=0 and `rst`=0, `acc` becomes (`opa` − second operand) mod 2^DATA_W.
- R2: On an edge with `op_valid`=1 and `op_is_cmp`=1, `acc` keeps its value, and all six flags take exactly the values a subtract with the same operands would give.
- R3: When `src_is_imm`=1, the second operand is `opb_imm` sign-extended to DATA_W bits (bit IMM_W−1 replicated). When `src_is_imm`=0, the second operand is `opb_reg`.
- R4: `flag_c` is 1 exactly when the unsigned value of `opa` is less than the unsigned value of the second operand.
- R5: `flag_z` is 1 exactly when the difference is zero. `flag_s` equals bit DATA_W−1 of the difference.
- R6: `flag_o` is 1 exactly when the operands' top bits differ and the difference's top bit differs from the top bit of `opa`.
- R7: `flag_a` is 1 exactly when `opa[3:0]` is less than bits [3:0] of the second operand, read as unsigned.
- R8: `flag_p` is 1 exactly when bits [7:0] of the difference contain an even number of ones.
- R9: On an edge with `op_valid`=0 and `rst`=0, `acc` and all flags keep their values, whatever the operand inputs hold.
- R10: On an edge with `rst`=1, `acc` and all flags become 0. This holds even when `op_valid`=1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe; one operation per cycle in which it is high |
| op_is_cmp | input | 1 | 0 = subtract, 1 = compare |
| src_is_imm | input | 1 | 0 = use `opb_reg`, 1 = use sign-extended `opb_imm` |
| opa | input | DATA_W | First operand (minuend) |
| opb_reg | input | DATA_W | Second operand, register form |
| opb_imm | input | IMM_W | Second operand, immediate form |
| acc | output | DATA_W | Accumulator |
| flag_c | output | 1 | Unsigned borrow |
| flag_z | output | 1 | Zero difference |
| flag_s | output | 1 | Sign of difference |
| flag_o | output | 1 | Signed overflow |
| flag_a | output | 1 | Low-nibble borrow |
| flag_p | output | 1 | Even parity of low byte |

## Verification
Two functions can fall in the same cycle: a synchronous reset and an operation strobe. The bench raises both together while carrying operands that would set several flags and change the accumulator, and it expects every output to read zero after that edge. A second case is a compare that directly follows a subtract. The bench judges it by requiring the accumulator to keep the subtract's result while the flags take the compare's values. A reference model in the bench computes every expected value arithmetically and tracks the accumulator separately from the flags.

// File: rtl/subcmp_pkg.sv
package subcmp_pkg;

  typedef enum logic {
    OP_SUB = 1'b0,
    OP_CMP = 1'b1
  } sc_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
    logic a;
    logic p;
  } sc_flags_t;

  localparam int unsigned NIBBLE_W = 4;
  localparam int unsigned PARITY_W = 8;

endpackage

// File: rtl/subcmp_operand_sel.sv
module subcmp_operand_sel #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IMM_W  = 4
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm_b,
  output logic [DATA_W-1:0] b_out
);

  localparam int unsigned EXT_W = (DATA_W > IMM_W) ? DATA_W - IMM_W : 1;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (DATA_W > IMM_W) begin : g_extend
      logic [EXT_W-1:0] fill;
      assign fill    = {EXT_W{imm_b[IMM_W-1]}};
      assign imm_ext = {fill, imm_b};
    end else begin : g_trunc
      assign imm_ext = imm_b[DATA_W-1:0];
    end
  endgenerate

  assign b_out = use_imm ? imm_ext : reg_b;

endmodule

// File: rtl/subcmp_subtractor.sv
module subcmp_subtractor #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] diff,
  output logic              borrow_out,
  output logic              nib_borrow
);
  import subcmp_pkg::*;

  localparam int unsigned NIBS = DATA_W / NIBBLE_W;

  logic [NIBS:0] brw;
  assign brw[0] = 1'b0;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic [NIBBLE_W:0] t;
    assign t = {1'b0, a[g*NIBBLE_W +: NIBBLE_W]}
             - {1'b0, b[g*NIBBLE_W +: NIBBLE_W]}
             - {{NIBBLE_W{1'b0}}, brw[g]};
    assign diff[g*NIBBLE_W +: NIBBLE_W] = t[NIBBLE_W-1:0];
    assign brw[g+1] = t[NIBBLE_W];
  end

  assign borrow_out = brw[NIBS];
  assign nib_borrow = brw[1];

endmodule

// File: rtl/subcmp_flag_gen.sv
module subcmp_flag_gen #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  a_msb,
  input  logic                  b_msb,
  input  logic [DATA_W-1:0]     diff,
  input  logic                  borrow,
  input  logic                  nib_borrow,
  output subcmp_pkg::sc_flags_t flags
);
  import subcmp_pkg::*;

  always_comb begin
    flags.c = borrow;
    flags.z = (diff == '0);
    flags.s = diff[DATA_W-1];
    flags.o = (a_msb ^ b_msb) & (diff[DATA_W-1] ^ a_msb);
    flags.a = nib_borrow;
    flags.p = ~^diff[PARITY_W-1:0];
  end

endmodule

// File: rtl/subcmp_flag_unit.sv
module subcmp_flag_unit #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IMM_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_is_cmp,
  input  logic              src_is_imm,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb_reg,
  input  logic [IMM_W-1:0]  opb_imm,
  output logic [DATA_W-1:0] acc,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_o,
  output logic              flag_a,
  output logic              flag_p
);
  import subcmp_pkg::*;

  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] diff;
  logic              borrow, nib_borrow;
  sc_flags_t         flags_nxt, flags_q;
  sc_op_e            op_kind;

  assign op_kind = sc_op_e'(op_is_cmp);

  subcmp_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .use_imm (src_is_imm),
    .reg_b   (opb_reg),
    .imm_b   (opb_imm),
    .b_out   (b_sel)
  );

  subcmp_subtractor #(.DATA_W(DATA_W)) u_sub (
    .a          (opa),
    .b          (b_sel),
    .diff       (diff),
    .borrow_out (borrow),
    .nib_borrow (nib_borrow)
  );

  subcmp_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .a_msb      (opa[DATA_W-1]),
    .b_msb      (b_sel[DATA_W-1]),
    .diff       (diff),
    .borrow     (borrow),
    .nib_borrow (nib_borrow),
    .flags      (flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      flags_q <= '0;
    end else if (op_valid) begin
      flags_q <= flags_nxt;
      if (op_kind == OP_SUB) acc <= diff;
    end
  end

  assign flag_c = flags_q.c;
  assign flag_z = flags_q.z;
  assign flag_s = flags_q.s;
  assign flag_o = flags_q.o;
  assign flag_a = flags_q.a;
  assign flag_p = flags_q.p;

endmodule

// File: rtl/subcmp_flags_chk.sv
module subcmp_flags_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IMM_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_is_cmp,
  input logic              src_is_imm,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb_reg,
  input logic [IMM_W-1:0]  opb_imm,
  input logic [DATA_W-1:0] acc,
  input logic              flag_c,
  input logic              flag_z,
  input logic              flag_s,
  input logic              flag_o,
  input logic              flag_a,
  input logic              flag_p
);

  logic [DATA_W-1:0] bx;
  logic [DATA_W-1:0] dx;
  logic [5:0]        fl;

  assign bx = src_is_imm ? DATA_W'($signed(opb_imm)) : opb_reg;
  assign dx = opa - bx;
  assign fl = {flag_c, flag_z, flag_s, flag_o, flag_a, flag_p};

  // R1
  sub_result_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && !op_is_cmp |=> acc == $past(dx));

  // R2
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_is_cmp |=> $stable(acc));

  // R4
  borrow_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_c == $past(opa < bx));

  // R5
  zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (flag_z == $past(dx == '0)) && (flag_s == $past(dx[DATA_W-1])));

  // R6
  overflow_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_o == $past((opa[DATA_W-1] != bx[DATA_W-1]) && (dx[DATA_W-1] != opa[DATA_W-1])));

  // R7
  nibble_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_a == $past(opa[3:0] < bx[3:0]));

  // R8
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_p == $past(~^dx[7:0]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(acc) && $stable(fl));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc == '0) && (fl == '0));

endmodule

bind subcmp_flag_unit subcmp_flags_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_is_cmp(op_is_cmp),
  .src_is_imm(src_is_imm), .opa(opa), .opb_reg(opb_reg), .opb_imm(opb_imm),
  .acc(acc), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s),
  .flag_o(flag_o), .flag_a(flag_a), .flag_p(flag_p)
);

// File: tb/subcmp_flag_unit_bench.sv
module subcmp_flag_unit_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0, op_is_cmp = 1'b0, src_is_imm = 1'b0;
  logic [7:0] opa = '0, opb_reg = '0;
  logic [3:0] opb_imm = '0;
  logic [7:0] acc;
  logic       flag_c, flag_z, flag_s, flag_o, flag_a, flag_p;

  int n_vec = 0;
  int n_bad = 0;
  bit over  = 0;

  int m_acc = 0;
  bit m_c, m_z, m_s, m_o, m_a, m_p;

  always #2 clk = ~clk;

  subcmp_flag_unit u_subcmp_flag_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_is_cmp(op_is_cmp),
    .src_is_imm(src_is_imm), .opa(opa), .opb_reg(opb_reg), .opb_imm(opb_imm),
    .acc(acc), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s),
    .flag_o(flag_o), .flag_a(flag_a), .flag_p(flag_p)
  );

  task automatic finish_up();
    if (!over) begin
      over = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic fld(string tag, int got, int exp, inout bit bad);
    if (got != exp) begin
      $display("FAIL %s: got %0d expected %0d (vector %0d)", tag, got, exp, n_vec);
      bad = 1;
    end
  endtask

  // Called at a negedge: drive, wait one cycle, compare at the next negedge.
  task automatic apply(bit r, bit v, bit cmp, bit imm, int a, int b, int im, string acc_tag);
    int bs, diff, sa, sb, sr;
    bit bad = 0;
    rst = r; op_valid = v; op_is_cmp = cmp; src_is_imm = imm;
    opa = 8'(a); opb_reg = 8'(b); opb_imm = 4'(im);
    if (r) begin
      m_acc = 0; {m_c, m_z, m_s, m_o, m_a, m_p} = '0;
    end else if (v) begin
      bs   = imm ? ((im >= 8) ? im + 240 : im) : b;  // R3 sign extension
      diff = (a - bs) & 255;
      sa   = (a  >= 128) ? a  - 256 : a;
      sb   = (bs >= 128) ? bs - 256 : bs;
      sr   = sa - sb;
      m_c  = (a < bs);
      m_z  = (diff == 0);
      m_s  = diff[7];
      m_o  = (sr > 127) || (sr < -128);
      m_a  = ((a & 15) < (bs & 15));
      m_p  = ~^diff[7:0];
      if (!cmp) m_acc = diff;
    end
    @(negedge clk);
    n_vec++;
    fld(acc_tag, int'(acc), m_acc, bad);
    fld("R4 carry",  int'(flag_c), int'(m_c), bad);
    fld("R5 zero",   int'(flag_z), int'(m_z), bad);
    fld("R5 sign",   int'(flag_s), int'(m_s), bad);
    fld("R6 ovf",    int'(flag_o), int'(m_o), bad);
    fld("R7 nibble", int'(flag_a), int'(m_a), bad);
    fld("R8 parity", int'(flag_p), int'(m_p), bad);
    if (bad) n_bad++;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    apply(1, 0, 0, 0, 0, 0, 0, "R10 acc");
    // R1: exhaustive subtract over register operands
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(0, 1, 0, 0, a, b, 0, "R1 acc");
    // R2: compares interleaved after a subtract that plants a known accumulator
    for (int a = 0; a < 256; a++) begin
      apply(0, 1, 0, 0, a, 3, 0, "R1 acc");
      for (int b = 0; b < 256; b += 17)
        apply(0, 1, 1, 0, a, b, 0, "R2 acc");
    end
    // R3: immediates, subtract and compare
    for (int a = 0; a < 256; a++)
      for (int im = 0; im < 16; im++)
        apply(0, 1, im[0], 1, a, 255 - a, im, "R3 acc");
    // R9: idle cycles with busy operand buses
    apply(0, 1, 0, 0, 200, 57, 0, "R1 acc");
    for (int k = 0; k < 32; k++)
      apply(0, 0, k[0], k[1], (k * 37) & 255, (k * 91) & 255, k & 15, "R9 acc");
    // R10: reset together with a strobe carrying flag-setting operands
    apply(0, 1, 0, 0, 5, 200, 0, "R1 acc");
    apply(1, 1, 0, 0, 0, 128, 0, "R10 acc");
    apply(0, 0, 0, 0, 9, 9, 0, "R10 acc");
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run still going, expected completion");
    finish_up();
  end

endmodule